// File: doc/BRIEF.md
# Two-Cache Snooping Invalidate Coherence Unit

This block keeps two per-processor caches coherent over one shared bus. Each cache controller holds a small direct-mapped array of one-word lines. Every line carries a state (Invalid, Shared or Modified), a tag and a data word. A processor issues a read or a write on its own request port and holds it until the block raises the done pulse for that port.

Hits finish in the same cycle without touching the bus. Any other access becomes a bus transaction. A round-robin arbiter grants the bus to one cache per cycle. The other cache snoops every granted transaction. A write gains exclusive ownership by broadcasting an invalidate or a read-exclusive, and any other copy of the line is dropped. A read miss for a line that the other cache holds Modified is served from that cache, and memory is written with the same word in the same cycle.

Memory sits behind a simple port with combinational read data and a write strobe. The whole block is used as the coherent data path between two cores and one shared memory.

Top module: `coh_pair_top`

## Requirements
- R1: A read that hits a Shared or Modified line with a matching tag raises done in the same cycle it is presented, returns the cached word, and puts no transaction on the bus.
- R2: A read miss places command 1 (read) on the bus. It installs the line as Shared, and the word returned is the latest value written to that address.
- R3: A write to a line held Shared places command 3 (invalidate) on the bus. The other cache drops its copy, so its next read of that address misses with command 1.
- R4: A write that misses places command 2 (read-exclusive) on the bus. The line is installed Modified, and any copy in the other cache is dropped.
- R5: When a cache holding a line Modified snoops a command 1 for it, that cache supplies the word. Memory is written with the word in the same cycle, and the line drops to Shared, so a later write by that cache needs a command 3.
- R6: The arbiter grants at most one cache per cycle. When both caches request, the cache not granted most recently wins. After reset, cache 0 has priority.
- R7: A miss whose indexed line is Modified with another tag first places command 4 (write-back) on the bus, without raising done. Memory then holds the evicted word, and the miss follows as its own transaction.
- R8: A write that hits a Modified line raises done in the same cycle with no bus transaction.
- R9: Across any interleaving of sequential accesses from both processors, every read returns the value of the last write to that address, whichever processor wrote it.
- R10: During reset, done, bus valid and the memory write strobe are all low, and all lines are Invalid.

Line address: the low IW bits of an address index the line and the remaining high bits form the tag. Bus command codes: 0 idle, 1 read, 2 read-exclusive, 3 invalidate, 4 write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_valid_i | input | 2 | Request valid, one bit per processor |
| cpu_write_i | input | 2 | 1 = write, 0 = read, per processor |
| cpu_addr_i | input | 2 x AW | Word address per processor |
| cpu_wdata_i | input | 2 x DW | Write data per processor |
| cpu_done_o | output | 2 | Request completes this cycle |
| cpu_rdata_o | output | 2 x DW | Read data, valid with done on a read |
| bus_valid_o | output | 1 | A transaction is on the bus this cycle |
| bus_owner_o | output | 1 | Index of the granted cache |
| bus_cmd_o | output | 3 | Bus command code |
| bus_addr_o | output | AW | Bus transaction address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, combinational on mem_addr_o |

## Verification
The assertions take for granted that each processor holds its request stable until done and drives no request while reset is active. They also take for granted that memory returns the word at mem_addr_o in the same cycle. The stimulus keeps to this: requests are set at the falling edge, held until done is seen, and dropped right after the rising edge that completes them. Memory is a bench array read combinationally. Random traffic is issued one access at a time, so the per-line expectation model stays exact. Two directed contention cases present requests from both processors in the same cycle, on different lines, so that arbitration order can be checked without the two accesses interacting.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE = 3'd0,
    CMD_RD   = 3'd1,
    CMD_RDX  = 3'd2,
    CMD_INV  = 3'd3,
    CMD_WB   = 3'd4
  } bus_cmd_e;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_M = 2'd2
  } line_st_e;
endpackage

// File: rtl/coh_bus_arb.sv
module coh_bus_arb (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] req_i,
  output logic [1:0] gnt_o
);
  logic prio_q;

  // R6: one grant per cycle, alternating under contention
  always_comb begin
    gnt_o = 2'b00;
    if (req_i[prio_q])       gnt_o[prio_q]  = 1'b1;
    else if (req_i[!prio_q]) gnt_o[!prio_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prio_q <= 1'b0;
    else if (|gnt_o) prio_q <= gnt_o[0];
  end
endmodule

// File: rtl/coh_cache_ctrl.sv
module coh_cache_ctrl
  import coh_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int IW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          bus_req_o,
  output bus_cmd_e      bus_cmd_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          grant_i,
  input  logic          snoop_valid_i,
  input  bus_cmd_e      snoop_cmd_i,
  input  logic [AW-1:0] snoop_addr_i,
  output logic          snoop_mod_o,
  output logic [DW-1:0] snoop_data_o,
  input  logic [DW-1:0] fill_i
);
  localparam int TW = AW - IW;
  localparam int NL = 1 << IW;

  line_st_e      st_q [NL];
  logic [TW-1:0] tg_q [NL];
  logic [DW-1:0] dt_q [NL];

  logic [IW-1:0] idx, s_idx;
  logic [TW-1:0] tag, s_tag;
  logic          hit, dirty_victim, s_match, local_ok, local_done;
  line_st_e      cur_st;
  bus_cmd_e      cmd;

  assign idx    = req_addr_i[IW-1:0];
  assign tag    = req_addr_i[AW-1:IW];
  assign s_idx  = snoop_addr_i[IW-1:0];
  assign s_tag  = snoop_addr_i[AW-1:IW];
  assign cur_st = st_q[idx];
  assign hit    = (cur_st != ST_I) && (tg_q[idx] == tag);
  assign dirty_victim = (cur_st == ST_M) && (tg_q[idx] != tag);
  assign s_match = snoop_valid_i && (st_q[s_idx] != ST_I) && (tg_q[s_idx] == s_tag);

  always_comb begin
    local_ok = 1'b0;
    cmd      = CMD_IDLE;
    if (req_valid_i) begin
      if (!req_write_i) begin
        if (hit)               local_ok = 1'b1;      // R1
        else if (dirty_victim) cmd = CMD_WB;         // R7
        else                   cmd = CMD_RD;         // R2
      end else begin
        if (hit && cur_st == ST_M) local_ok = 1'b1;  // R8
        else if (hit)              cmd = CMD_INV;    // R3
        else if (dirty_victim)     cmd = CMD_WB;
        else                       cmd = CMD_RDX;    // R4
      end
    end
  end

  // a local hit waits one cycle if the other cache is transacting on the same line
  assign local_done  = local_ok && !(s_match && (s_idx == idx));
  assign bus_req_o   = (cmd != CMD_IDLE);
  assign bus_cmd_o   = cmd;
  assign bus_addr_o  = (cmd == CMD_WB) ? {tg_q[idx], idx} : req_addr_i;
  assign bus_wdata_o = dt_q[idx];
  assign done_o      = local_done || (grant_i && cmd != CMD_WB);
  assign rdata_o     = hit ? dt_q[idx] : fill_i;

  assign snoop_mod_o  = s_match && (st_q[s_idx] == ST_M) &&
                        (snoop_cmd_i == CMD_RD || snoop_cmd_i == CMD_RDX);
  assign snoop_data_o = dt_q[s_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NL; i++) begin
        st_q[i] <= ST_I;
        tg_q[i] <= '0;
        dt_q[i] <= '0;
      end
    end else begin
      if (s_match) begin
        unique case (snoop_cmd_i)
          CMD_RD:           if (st_q[s_idx] == ST_M) st_q[s_idx] <= ST_S;  // R5
          CMD_RDX, CMD_INV: st_q[s_idx] <= ST_I;
          default: ;
        endcase
      end
      if (grant_i) begin
        unique case (cmd)
          CMD_WB: st_q[idx] <= ST_I;
          CMD_RD: begin
            st_q[idx] <= ST_S;
            tg_q[idx] <= tag;
            dt_q[idx] <= fill_i;
          end
          CMD_RDX, CMD_INV: begin
            st_q[idx] <= ST_M;
            tg_q[idx] <= tag;
            dt_q[idx] <= req_wdata_i;
          end
          default: ;
        endcase
      end else if (local_done && req_write_i) begin
        dt_q[idx] <= req_wdata_i;
      end
    end
  end
endmodule

// File: rtl/coh_pair_top.sv
module coh_pair_top
  import coh_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int IW = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          cpu_valid_i,
  input  logic [1:0]          cpu_write_i,
  input  logic [1:0][AW-1:0]  cpu_addr_i,
  input  logic [1:0][DW-1:0]  cpu_wdata_i,
  output logic [1:0]          cpu_done_o,
  output logic [1:0][DW-1:0]  cpu_rdata_o,
  output logic                bus_valid_o,
  output logic                bus_owner_o,
  output logic [2:0]          bus_cmd_o,
  output logic [AW-1:0]       bus_addr_o,
  output logic                mem_we_o,
  output logic [AW-1:0]       mem_addr_o,
  output logic [DW-1:0]       mem_wdata_o,
  input  logic [DW-1:0]       mem_rdata_i
);
  logic [1:0]    bus_req, gnt, s_mod;
  bus_cmd_e      c_cmd   [2];
  logic [AW-1:0] c_addr  [2];
  logic [DW-1:0] c_wdata [2];
  logic [DW-1:0] s_data  [2];
  bus_cmd_e      cmd;
  logic          owner, supply;
  logic [AW-1:0] addr;
  logic [DW-1:0] fill, supply_data;

  coh_bus_arb u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (bus_req),
    .gnt_o  (gnt)
  );

  assign owner       = gnt[1];
  assign bus_valid_o = |gnt;
  assign cmd         = bus_valid_o ? c_cmd[owner] : CMD_IDLE;
  assign addr        = bus_valid_o ? c_addr[owner] : '0;
  assign supply      = bus_valid_o && s_mod[!owner];
  assign supply_data = s_data[!owner];
  assign fill        = supply ? supply_data : mem_rdata_i;

  assign bus_owner_o = owner;
  assign bus_cmd_o   = cmd;
  assign bus_addr_o  = addr;
  assign mem_addr_o  = addr;
  assign mem_we_o    = bus_valid_o && (cmd == CMD_WB || supply);
  assign mem_wdata_o = (cmd == CMD_WB) ? c_wdata[owner] : supply_data;

  for (genvar g = 0; g < 2; g++) begin : g_cache
    coh_cache_ctrl #(.AW(AW), .DW(DW), .IW(IW)) u_cache (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .req_valid_i   (cpu_valid_i[g]),
      .req_write_i   (cpu_write_i[g]),
      .req_addr_i    (cpu_addr_i[g]),
      .req_wdata_i   (cpu_wdata_i[g]),
      .done_o        (cpu_done_o[g]),
      .rdata_o       (cpu_rdata_o[g]),
      .bus_req_o     (bus_req[g]),
      .bus_cmd_o     (c_cmd[g]),
      .bus_addr_o    (c_addr[g]),
      .bus_wdata_o   (c_wdata[g]),
      .grant_i       (gnt[g]),
      .snoop_valid_i (bus_valid_o && !gnt[g]),
      .snoop_cmd_i   (cmd),
      .snoop_addr_i  (addr),
      .snoop_mod_o   (s_mod[g]),
      .snoop_data_o  (s_data[g]),
      .fill_i        (fill)
    );
  end
endmodule

// File: rtl/coh_pair_checker.sv
module coh_pair_checker
  import coh_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         gnt_i,
  input logic [1:0]         bus_req_i,
  input logic [1:0]         cpu_valid_i,
  input logic [1:0]         cpu_done_o,
  input logic [1:0][DW-1:0] cpu_rdata_o,
  input logic               bus_valid_o,
  input logic               bus_owner_o,
  input logic [2:0]         bus_cmd_o,
  input logic [AW-1:0]      bus_addr_o,
  input logic               mem_we_o,
  input logic [DW-1:0]      mem_wdata_o
);
  assert_one_grant_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_i));

  assert_round_robin_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&bus_req_i && $past(|gnt_i)) |-> (gnt_i != $past(gnt_i)));

  assert_done_needs_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_done_o & ~cpu_valid_i) == 2'b00);

  assert_mem_write_on_bus_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (bus_valid_o && bus_cmd_o != CMD_INV && bus_cmd_o != CMD_IDLE));

  assert_supply_matches_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_cmd_o == CMD_RD && mem_we_o) |-> (cpu_rdata_o[bus_owner_o] == mem_wdata_o));

  assert_wb_no_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_cmd_o == CMD_WB) |-> (!cpu_done_o[bus_owner_o] && mem_we_o));

  assert_idle_bus_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_valid_o |-> (bus_cmd_o == CMD_IDLE && bus_addr_o == '0));
endmodule

bind coh_pair_top coh_pair_checker #(.AW(AW), .DW(DW)) u_coh_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gnt_i       (gnt),
  .bus_req_i   (bus_req),
  .cpu_valid_i (cpu_valid_i),
  .cpu_done_o  (cpu_done_o),
  .cpu_rdata_o (cpu_rdata_o),
  .bus_valid_o (bus_valid_o),
  .bus_owner_o (bus_owner_o),
  .bus_cmd_o   (bus_cmd_o),
  .bus_addr_o  (bus_addr_o),
  .mem_we_o    (mem_we_o),
  .mem_wdata_o (mem_wdata_o)
);

// File: tb/coh_pair_top_bench.sv
module coh_pair_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [1:0]         cpu_valid, cpu_write;
  logic [1:0][AW-1:0] cpu_addr;
  logic [1:0][DW-1:0] cpu_wdata;
  logic [1:0]         cpu_done;
  logic [1:0][DW-1:0] cpu_rdata;
  logic               bus_valid, bus_owner, mem_we;
  logic [2:0]         bus_cmd;
  logic [AW-1:0]      bus_addr, mem_addr;
  logic [DW-1:0]      mem_wdata, mem_rdata;

  logic [DW-1:0] mem    [16];
  logic [DW-1:0] golden [16];
  int            bst [2][4];
  logic [1:0]    btg [2][4];
  int n_checks = 0, n_err = 0, cyc = 0;

  logic [DW-1:0] res_rd  [2];
  int            res_cyc [2];
  int            res_cmd [2];
  bit            res_wb  [2];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk_i) if (mem_we) mem[mem_addr] <= mem_wdata;

  coh_pair_top #(.AW(AW), .DW(DW), .IW(2)) u_coh_pair_top (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cpu_valid_i(cpu_valid), .cpu_write_i(cpu_write),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_done_o(cpu_done), .cpu_rdata_o(cpu_rdata),
    .bus_valid_o(bus_valid), .bus_owner_o(bus_owner),
    .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected bus activity from the line-state model (states: 0 I, 1 S, 2 M)
  task automatic predict(input int c, input bit w, input logic [3:0] a,
                         output int ecmd, output bit ewb, output string tg);
    int idx = int'(a[1:0]);
    bit hit = bst[c][idx] != 0 && btg[c][idx] == a[3:2];
    bit dv  = bst[c][idx] == 2 && btg[c][idx] != a[3:2];
    ewb = 1'b0;
    if (!w) begin
      if (hit) begin ecmd = 0; tg = "R1"; end
      else begin ecmd = 1; ewb = dv; tg = "R2"; end
    end else begin
      if (hit && bst[c][idx] == 2) begin ecmd = 0; tg = "R8"; end
      else if (hit) begin ecmd = 3; tg = "R3"; end
      else begin ecmd = 2; ewb = dv; tg = "R4"; end
    end
  endtask

  task automatic commit(input int c, input bit w, input logic [3:0] a, input logic [7:0] d);
    int idx = int'(a[1:0]);
    int o = 1 - c;
    bit hit = bst[c][idx] != 0 && btg[c][idx] == a[3:2];
    bit oh  = bst[o][idx] != 0 && btg[o][idx] == a[3:2];
    if (!w) begin
      if (!hit) begin bst[c][idx] = 1; btg[c][idx] = a[3:2]; end
      if (oh && bst[o][idx] == 2) bst[o][idx] = 1;
    end else begin
      bst[c][idx] = 2; btg[c][idx] = a[3:2];
      if (oh) bst[o][idx] = 0;
      golden[a] = d;
    end
  endtask

  task automatic drive(input int c, input bit w, input logic [3:0] a, input logic [7:0] d);
    bit fin = 1'b0;
    @(negedge clk_i);
    cpu_valid[c] = 1'b1; cpu_write[c] = w; cpu_addr[c] = a; cpu_wdata[c] = d;
    res_cmd[c] = 0; res_wb[c] = 1'b0;
    while (!fin) begin
      #1;
      if (bus_valid && int'(bus_owner) == c && bus_cmd == 3'd4) res_wb[c] = 1'b1;
      if (cpu_done[c]) begin
        res_rd[c] = cpu_rdata[c];
        res_cyc[c] = cyc;
        if (bus_valid && int'(bus_owner) == c) res_cmd[c] = int'(bus_cmd);
        fin = 1'b1;
      end else begin
        @(negedge clk_i);
      end
    end
    @(posedge clk_i);
    #1 cpu_valid[c] = 1'b0;
  endtask

  task automatic do_op(input int c, input bit w, input logic [3:0] a, input logic [7:0] d);
    int ecmd; bit ewb; string tg;
    int o = 1 - c;
    int idx = int'(a[1:0]);
    bit hit = bst[c][idx] != 0 && btg[c][idx] == a[3:2];
    bit sup = !w && !hit && bst[o][idx] == 2 && btg[o][idx] == a[3:2];
    logic [3:0] vaddr = {btg[c][idx], a[1:0]};
    predict(c, w, a, ecmd, ewb, tg);
    drive(c, w, a, d);
    chk(res_cmd[c] == ecmd, tg, res_cmd[c], ecmd);
    chk(res_wb[c] == ewb, "R7", int'(res_wb[c]), int'(ewb));
    if (ewb) chk(mem[vaddr] == golden[vaddr], "R7", int'(mem[vaddr]), int'(golden[vaddr]));
    if (!w) chk(res_rd[c] == golden[a], "R9", int'(res_rd[c]), int'(golden[a]));
    if (sup) chk(mem[a] == golden[a], "R5", int'(mem[a]), int'(golden[a]));
    commit(c, w, a, d);
  endtask

  task automatic do_pair(input bit w0, input logic [3:0] a0, input logic [7:0] d0,
                         input bit w1, input logic [3:0] a1, input logic [7:0] d1,
                         input int first);
    int e0, e1; bit b0, b1; string t0, t1;
    predict(0, w0, a0, e0, b0, t0);
    predict(1, w1, a1, e1, b1, t1);
    fork
      drive(0, w0, a0, d0);
      drive(1, w1, a1, d1);
    join
    chk(res_cmd[0] == e0, t0, res_cmd[0], e0);
    chk(res_cmd[1] == e1, t1, res_cmd[1], e1);
    chk(res_cyc[first] + 1 == res_cyc[1-first], "R6", res_cyc[1-first] - res_cyc[first], 1);
    commit(0, w0, a0, d0);
    commit(1, w1, a1, d1);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_checks++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    int unsigned seed = $urandom(32'h5eed);
    cpu_valid = '0; cpu_write = '0; cpu_addr = '0; cpu_wdata = '0;
    for (int i = 0; i < 16; i++) begin
      mem[i] = 8'($urandom);
      golden[i] = mem[i];
    end
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 4; i++) begin bst[c][i] = 0; btg[c][i] = '0; end
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); #1;
    // R10: reset state
    chk(cpu_done == 2'b00, "R10", int'(cpu_done), 0);
    chk(bus_valid == 1'b0, "R10", int'(bus_valid), 0);
    chk(mem_we == 1'b0, "R10", int'(mem_we), 0);
    rst_ni = 1'b1;

    // R6: cold contention, cache 0 first; then cache 1 first after cache 0 used the bus
    do_pair(1'b0, 4'h1, 8'h00, 1'b0, 4'h2, 8'h00, 0);
    do_op(0, 1'b0, 4'h3, 8'h00);
    do_pair(1'b1, 4'h5, 8'hA5, 1'b1, 4'h6, 8'h66, 1);

    // invalidate sequence on one address; cache 0 first evicts its dirty 0x5 (R7)
    do_op(0, 1'b0, 4'h9, 8'h00);
    do_op(1, 1'b0, 4'h9, 8'h00);
    do_op(0, 1'b1, 4'h9, 8'h01);        // R3 invalidate
    do_op(1, 1'b0, 4'h9, 8'h00);        // R5 supply from owner
    chk(mem[9] == 8'h01, "R5", int'(mem[9]), 1);
    chk(res_rd[1] == 8'h01, "R5", int'(res_rd[1]), 1);
    do_op(0, 1'b0, 4'h9, 8'h00);        // R1 hit returns 1
    chk(res_rd[0] == 8'h01, "R1", int'(res_rd[0]), 1);
    do_op(0, 1'b1, 4'h9, 8'h22);        // owner dropped to Shared: invalidate again
    do_op(0, 1'b1, 4'h9, 8'h23);        // R8 hit in Modified
    do_op(1, 1'b0, 4'h9, 8'h00);

    // R9: random sequential traffic from both processors
    for (int n = 0; n < 400; n++) begin
      int c = int'($urandom % 2);
      bit w = 1'($urandom % 2);
      logic [3:0] a = 4'($urandom % 16);
      logic [7:0] d = 8'($urandom);
      do_op(c, w, a, d);
    end
    for (int a = 0; a < 16; a++) begin
      do_op(0, 1'b0, 4'(a), 8'h00);
      do_op(1, 1'b0, 4'(a), 8'h00);
    end
    if (seed == 32'hFFFF_FFFF) $display("seed");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule